// File: doc/BRIEF.md
# Halfword Load Execution Unit

This unit carries out one 32-bit load-halfword instruction word at a time. It decodes the word and tests its condition code against the four arithmetic flags. It then forms an effective address from a base register and either an 8-bit immediate or a second register. It fetches two bytes over a request/ready memory port, widens the returned halfword to a 32-bit word with zero fill, and writes the register file.

The base value comes from a combinational register-file read port. When the base field names the program counter, the base is instead the word-aligned `pc` input plus eight. When writeback applies, the updated base is written one cycle ahead of the destination. A destination that shares its index with the base therefore ends up holding the loaded data. Each instruction ends with a one-cycle `done` pulse, and `err` marks an instruction the unit refused.

Top module: `hword_load_unit`

## Requirements
- R1: An instruction is legal only if bits 27:25 are 000, bit 20 is 1 and bits 7:4 are 1011. When bit 22 is 0 (register offset), bits 11:8 must also be 0000. An illegal word performs no access and no write, and it ends with `done` and `err` high together.
- R2: When bit 22 is 1, the offset is the 8-bit value {bits 11:8, bits 3:0}, zero-extended to 32 bits.
- R3: When bit 22 is 0, the offset is the register-file value at index bits 3:0, read through the `rf_off_idx`/`rf_off_data` port.
- R4: With bit 23 at 1 the offset is added to the base; with bit 23 at 0 it is subtracted.
- R5: With bit 24 at 1 the memory access uses the offset address. With bit 24 at 0 it uses the unmodified base.
- R6: Writeback happens when bit 21 is 1 or bit 24 is 0. It writes the offset address into the register named by bits 19:16.
- R7: The destination named by bits 15:12 receives the 16-bit read data with bits 31:16 cleared.
- R8: The condition in bits 31:28 is tested against flags {N,Z,C,V} = `flags[3:0]`. The codes are 0 EQ, 1 NE, 2 CS, 3 CC, 4 MI, 5 PL, 6 VS, 7 VC, 8 HI, 9 LS, 10 GE, 11 LT, 12 GT, 13 LE and 14 always. A failing test gives `done` with no memory request and no register write.
- R9: Condition code 1111 is undefined. It gives `done` with `err`, no access and no write.
- R10: When writeback applies, the base write takes the cycle before the destination write. If the two indices match, the register's final value is the loaded data.
- R11: When bits 19:16 are 1111, the base is {`pc`[31:2],00} + 8. Writeback combined with this base is illegal (`err`).
- R12: `mem_req` stays high, with `mem_addr` stable and `mem_size` = 01 (two bytes), until the cycle `mem_ready` is sampled high. Data is taken on the single cycle `mem_rvalid` is high. `done` is a one-cycle pulse that follows the last register write. `start` is accepted only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction present on `instr` this cycle |
| instr | input | 32 | Instruction word |
| flags | input | 4 | N, Z, C, V from bit 3 down to bit 0 |
| pc | input | 32 | Address of the current instruction |
| busy | output | 1 | An instruction is in progress |
| rf_base_idx | output | 4 | Base register read index |
| rf_base_data | input | 32 | Base register read data (same cycle) |
| rf_off_idx | output | 4 | Offset register read index |
| rf_off_data | input | 32 | Offset register read data (same cycle) |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_size | output | 2 | Access size, 01 = two bytes |
| mem_ready | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read halfword |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 4 | Register write index |
| wr_data | output | 32 | Register write data |
| done | output | 1 | Instruction finished (one cycle) |
| err | output | 1 | Instruction refused, valid with `done` |

## Verification
The embedded properties watch, on every cycle, that a waiting request holds its address and that `done` lasts exactly one cycle. They also check that `err` appears only alongside `done`, that a failing condition never leads to a request or a write, and that a PC-based load never writes register 15 back. Address arithmetic, the offset forms and the condition table can only be confirmed by the bench's sweeps. The same goes for the zero fill, the order of the two writes and the final value of a shared register. The bench compares each of these against values it computes from the instruction fields.

// File: rtl/hld_pkg.sv
package hld_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int IDX_W  = 4;
    localparam int IMM_W  = 8;
    localparam logic [1:0]       SIZE_HALF = 2'b01;
    localparam logic [IDX_W-1:0] PC_IDX    = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_WBASE = 3'd3,
        ST_WDEST = 3'd4,
        ST_FIN   = 3'd5
    } state_e;

    typedef struct packed {
        state_e              st;
        logic [WORD_W-1:0]   acc_addr;
        logic [WORD_W-1:0]   new_base;
        logic [IDX_W-1:0]    rn;
        logic [IDX_W-1:0]    rt;
        logic                wback;
        logic [HALF_W-1:0]   hword;
        logic                err;
    } ctx_t;
endpackage

// File: rtl/hld_decode.sv
module hld_decode
    import hld_pkg::*;
(
    input  logic [27:0]       fields,
    output logic              legal,
    output logic              imm_form,
    output logic              add,
    output logic              index,
    output logic              wback,
    output logic              literal,
    output logic [IDX_W-1:0]  rn,
    output logic [IDX_W-1:0]  rt,
    output logic [IMM_W-1:0]  imm8
);
    logic shape_ok;
    logic regform_ok;

    always_comb begin
        shape_ok   = (fields[27:25] == 3'b000) && fields[20] && (fields[7:4] == 4'b1011);
        imm_form   = fields[22];
        add        = fields[23];
        index      = fields[24];
        wback      = fields[21] | ~fields[24];
        rn         = fields[19:16];
        rt         = fields[15:12];
        imm8       = {fields[11:8], fields[3:0]};
        literal    = (rn == PC_IDX);
        regform_ok = imm_form || (fields[11:8] == 4'b0000);
        legal      = shape_ok && regform_ok && !(literal && wback);
    end
endmodule

// File: rtl/hld_cond_check.sv
module hld_cond_check (
    input  logic [3:0] cond,
    input  logic [3:0] nzcv,
    output logic       pass,
    output logic       undef
);
    logic n, z, c, v;
    assign {n, z, c, v} = nzcv;

    always_comb begin
        undef = (cond == 4'hF);
        unique case (cond)
            4'h0: pass = z;
            4'h1: pass = !z;
            4'h2: pass = c;
            4'h3: pass = !c;
            4'h4: pass = n;
            4'h5: pass = !n;
            4'h6: pass = v;
            4'h7: pass = !v;
            4'h8: pass = c && !z;
            4'h9: pass = !c || z;
            4'hA: pass = (n == v);
            4'hB: pass = (n != v);
            4'hC: pass = !z && (n == v);
            4'hD: pass = z || (n != v);
            4'hE: pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/hld_addr_gen.sv
module hld_addr_gen #(
    parameter int W = 32
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] offset,
    input  logic         add,
    input  logic         index,
    output logic [W-1:0] offs_addr,
    output logic [W-1:0] acc_addr
);
    always_comb begin
        offs_addr = add ? (base + offset) : (base - offset);
        acc_addr  = index ? offs_addr : base;
    end
endmodule

// File: rtl/hword_load_unit.sv
module hword_load_unit
    import hld_pkg::*;
#(
    parameter int PC_AHEAD = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [WORD_W-1:0]   instr,
    input  logic [3:0]          flags,
    input  logic [WORD_W-1:0]   pc,
    output logic                busy,
    output logic [IDX_W-1:0]    rf_base_idx,
    input  logic [WORD_W-1:0]   rf_base_data,
    output logic [IDX_W-1:0]    rf_off_idx,
    input  logic [WORD_W-1:0]   rf_off_data,
    output logic                mem_req,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [1:0]          mem_size,
    input  logic                mem_ready,
    input  logic                mem_rvalid,
    input  logic [HALF_W-1:0]   mem_rdata,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx,
    output logic [WORD_W-1:0]   wr_data,
    output logic                done,
    output logic                err
);
    localparam int ZPAD = WORD_W - HALF_W;

    logic              legal, imm_form, add, index, wback, literal;
    logic [IDX_W-1:0]  rn, rt;
    logic [IMM_W-1:0]  imm8;
    logic              c_pass, c_undef;
    logic [WORD_W-1:0] base_val, offset_val, offs_addr, acc_addr;
    ctx_t              q, d;

    hld_decode u_dec (
        .fields  (instr[27:0]),
        .legal   (legal),
        .imm_form(imm_form),
        .add     (add),
        .index   (index),
        .wback   (wback),
        .literal (literal),
        .rn      (rn),
        .rt      (rt),
        .imm8    (imm8)
    );

    hld_cond_check u_cond (
        .cond (instr[31:28]),
        .nzcv (flags),
        .pass (c_pass),
        .undef(c_undef)
    );

    always_comb begin
        base_val   = literal ? ({pc[WORD_W-1:2], 2'b00} + WORD_W'(PC_AHEAD)) : rf_base_data;
        offset_val = imm_form ? {{(WORD_W-IMM_W){1'b0}}, imm8} : rf_off_data;
    end

    hld_addr_gen #(.W(WORD_W)) u_agen (
        .base     (base_val),
        .offset   (offset_val),
        .add      (add),
        .index    (index),
        .offs_addr(offs_addr),
        .acc_addr (acc_addr)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.rn       = rn;
                    d.rt       = rt;
                    d.wback    = wback;
                    d.acc_addr = acc_addr;
                    d.new_base = offs_addr;
                    d.err      = 1'b0;
                    if (!legal || c_undef) begin
                        d.err = 1'b1;
                        d.st  = ST_FIN;
                    end else if (!c_pass) begin
                        d.st  = ST_FIN;
                    end else begin
                        d.st  = ST_REQ;
                    end
                end
            end
            ST_REQ:   if (mem_ready) d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    d.hword = mem_rdata;
                    d.st    = q.wback ? ST_WBASE : ST_WDEST;
                end
            end
            ST_WBASE: d.st = ST_WDEST;
            ST_WDEST: d.st = ST_FIN;
            ST_FIN: begin
                d.st  = ST_IDLE;
                d.err = 1'b0;
            end
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        busy        = (q.st != ST_IDLE);
        rf_base_idx = rn;
        rf_off_idx  = instr[3:0];
        mem_req     = (q.st == ST_REQ);
        mem_addr    = q.acc_addr;
        mem_size    = SIZE_HALF;
        wr_en       = (q.st == ST_WBASE) || (q.st == ST_WDEST);
        wr_idx      = (q.st == ST_WBASE) ? q.rn : q.rt;
        wr_data     = (q.st == ST_WBASE) ? q.new_base : {{ZPAD{1'b0}}, q.hword};
        done        = (q.st == ST_FIN);
        err         = q.err;
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_cond_fail_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !c_pass) |=> (!mem_req && !wr_en));

    assert_literal_no_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WBASE) |-> (wr_idx != PC_IDX));
endmodule

// File: tb/tb_hword_load_unit.sv
`timescale 1ns/1ps
module tb_hword_load_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  flags = '0;
    logic [31:0] pc = '0;
    logic        busy;
    logic [3:0]  rf_base_idx, rf_off_idx;
    logic [31:0] rf_base_data, rf_off_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic        done, err;

    logic [31:0] regs [16];
    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    always_comb begin
        rf_base_data = regs[rf_base_idx];
        rf_off_data  = regs[rf_off_idx];
    end

    hword_load_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .flags(flags), .pc(pc),
        .busy(busy), .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
        .rf_off_idx(rf_off_idx), .rf_off_data(rf_off_data), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .done(done), .err(err)
    );

    function automatic logic [15:0] memf(input logic [31:0] a);
        return a[16:1] ^ 16'hC35A ^ {a[31:24], a[7:0]};
    endfunction

    function automatic bit cond_ok(input logic [3:0] cc, input logic [3:0] f);
        bit nf = f[3], zf = f[2], cf = f[1], vf = f[0];
        bit r;
        case (cc[3:1])
            3'd0: r = zf;
            3'd1: r = cf;
            3'd2: r = nf;
            3'd3: r = vf;
            3'd4: r = cf && !zf;
            3'd5: r = (nf == vf);
            3'd6: r = !zf && (nf == vf);
            default: r = 1'b1;
        endcase
        if (cc[0] && cc[3:1] != 3'd7) r = !r;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [3:0] fl, input int dly, input int seed);
        logic [3:0]  cc, rn, rt;
        bit          shape, immf, e_err, e_exec, e_wb, fin, got_err;
        logic [31:0] base, off, oa, ea, edata, lat_addr;
        logic [1:0]  lat_size;
        logic [3:0]  lidx [4];
        logic [31:0] ldat [4];
        int          nw, n_req, hold_bad, rs, cnt;
        string       atag;
        for (int i = 0; i < 16; i++) regs[i] = 32'h2000_0000 + i * 32'h0001_0102 + seed * 32'h0000_0044;
        @(negedge clk);
        pc    = 32'h0000_8001 + seed * 32'h0000_0107;
        instr = ins;
        flags = fl;
        start = 1'b1;
        cc    = ins[31:28];
        rn    = ins[19:16];
        rt    = ins[15:12];
        shape = ins[27:25] == 3'b000 && ins[20] && ins[7:4] == 4'hB;
        immf  = ins[22];
        e_wb  = ins[21] || !ins[24];
        e_err = !shape || (!immf && ins[11:8] != 4'h0) || (rn == 4'hF && e_wb) || cc == 4'hF;
        e_exec = !e_err && cond_ok(cc, fl);
        base  = (rn == 4'hF) ? ((pc & ~32'h3) + 32'd8) : regs[rn];
        off   = immf ? {24'h0, ins[11:8], ins[3:0]} : regs[ins[3:0]];
        oa    = ins[23] ? base + off : base - off;
        ea    = ins[24] ? oa : base;
        edata = {16'h0, memf(ea)};
        atag  = (rn == 4'hF) ? "R11 R4 R5 addr" : (immf ? "R2 R4 R5 addr" : "R3 R4 R5 addr");
        @(negedge clk);
        start = 1'b0;
        fin = 0; got_err = 0; nw = 0; n_req = 0; hold_bad = 0; rs = 0; cnt = 0;
        lat_addr = '0; lat_size = '0;
        for (int k = 0; k < 60 && !fin; k++) begin
            mem_ready  = 1'b0;
            mem_rvalid = 1'b0;
            case (rs)
                0: if (mem_req) begin
                       n_req++;
                       lat_addr = mem_addr;
                       lat_size = mem_size;
                       cnt = dly;
                       if (cnt == 0) begin mem_ready = 1'b1; rs = 2; end
                       else rs = 1;
                   end
                1: begin
                       if (!mem_req || mem_addr != lat_addr) hold_bad++;
                       cnt--;
                       if (cnt == 0) begin mem_ready = 1'b1; rs = 2; end
                   end
                2: begin
                       if (mem_req) n_req++;
                       mem_rvalid = 1'b1;
                       mem_rdata  = memf(lat_addr);
                       rs = 3;
                   end
                default: rs = 0;
            endcase
            if (wr_en) begin
                if (nw < 4) begin lidx[nw] = wr_idx; ldat[nw] = wr_data; end
                nw++;
                regs[wr_idx] = wr_data;
            end
            if (done) begin fin = 1; got_err = err; end
            @(negedge clk);
        end
        mem_ready = 1'b0; mem_rvalid = 1'b0;
        check(fin, "R12 done timeout", {31'h0, fin}, 32'h1);
        check(got_err == e_err, "R1 R9 R11 err", {31'h0, got_err}, {31'h0, e_err});
        if (!e_exec) begin
            check(n_req == 0, "R8 R1 no request", n_req, 0);
            check(nw == 0, "R8 R1 no write", nw, 0);
        end else begin
            check(n_req == 1, "R12 one request", n_req, 1);
            check(lat_addr == ea, atag, lat_addr, ea);
            check(lat_size == 2'b01, "R12 size", {30'h0, lat_size}, 32'h1);
            check(hold_bad == 0, "R12 hold", hold_bad, 0);
            check(nw == (e_wb ? 2 : 1), "R6 write count", nw, e_wb ? 2 : 1);
            if (e_wb && nw == 2) begin
                check(lidx[0] == rn, "R10 base first idx", {28'h0, lidx[0]}, {28'h0, rn});
                check(ldat[0] == oa, "R6 base value", ldat[0], oa);
                check(lidx[1] == rt, "R10 dest second idx", {28'h0, lidx[1]}, {28'h0, rt});
                check(ldat[1] == edata, "R7 dest data", ldat[1], edata);
            end else if (!e_wb && nw == 1) begin
                check(lidx[0] == rt, "R7 dest idx", {28'h0, lidx[0]}, {28'h0, rt});
                check(ldat[0] == edata, "R7 dest data", ldat[0], edata);
            end
            check(regs[rt] == edata, "R10 final dest", regs[rt], edata);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_tests, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [7:0]  iv;
        logic [3:0]  rnv, rtv;
        int          seed = 0;
        for (int i = 0; i < 16; i++) regs[i] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !wr_en && !done && !err, "R12 reset idle",
              {27'h0, busy, mem_req, wr_en, done, err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 R9: every condition code against every flag pattern
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                w = {cc[3:0], 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 4'd3, 4'h1, 4'hB, 4'h4};
                run(w, f[3:0], (cc + f) % 4, seed++);
            end
        end
        // R2 R3 R4 R5 R6 R10 R11: addressing modes, offset forms, base choices
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 4; k++) begin
                case (k)
                    0: iv = 8'h00;
                    1: iv = 8'h01;
                    2: iv = 8'hFF;
                    default: iv = 8'h5A;
                endcase
                for (int form = 0; form < 2; form++) begin
                    for (int bs = 0; bs < 2; bs++) begin
                        for (int ts = 0; ts < 2; ts++) begin
                            rnv = bs[0] ? 4'hF : 4'h5;
                            rtv = ts[0] ? rnv : 4'h7;
                            w = {4'hE, 3'b000, m[2], m[1], form[0], m[0], 1'b1, rnv, rtv,
                                 form[0] ? iv[7:4] : 4'h0, 4'hB, iv[3:0]};
                            run(w, 4'h0, (m + k) % 3, seed++);
                        end
                    end
                end
            end
        end
        // R1: malformed words
        w = {4'hE, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 4'd3, 4'h1, 4'hB, 4'h4};
        run(w & ~32'h0010_0000, 4'h0, 0, seed++);
        run((w & ~32'h0000_00F0) | 32'h0000_00D0, 4'h0, 0, seed++);
        run(w | 32'h0200_0000, 4'h0, 0, seed++);
        run((w & ~32'h0040_0000) | 32'h0000_0300, 4'h0, 1, seed++);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule